// File: doc/BRIEF.md
# Predicated Vector XOR Reduction Unit

This unit folds a wide vector register into a single scalar by XOR-ing together every element that a predicate marks as active. The element width (8, 16, 32 or 64 bits) is picked at run time from a two-bit size field carried in a 32-bit instruction word. The same word is checked against a fixed opcode pattern, and the register indices it names are extracted. The vector length is a build-time parameter. The predicate carries one bit for each byte of the vector, so how it is read depends on the selected element width.

A caller presents the instruction word together with the vector and predicate operands on a valid/ready input. The operand-register indices are returned combinationally so that a register file can be read. A matching word produces a registered result, zero-extended to 64 bits, on a valid/ready output together with the destination index and element size. A word that does not match raises an illegal flag, is consumed, and produces no result. No flags of any other kind are generated.

Top module: `xorv_unit`

## Requirements
- R1: For a matching instruction, `result_o` equals the bitwise XOR of all active elements of `vec_i` at the selected width. Element e occupies bits [e*W +: W].
- R2: Inactive elements contribute zero. When no element is active, the result is zero.
- R3: Element e is active exactly when `pred_i[e*W/8]` is 1, which is the predicate bit of its lowest byte. The predicate bits for the element's other bytes have no effect.
- R4: The size field `instr_i[23:22]` selects 8-bit (0), 16-bit (1), 32-bit (2) or 64-bit (3) elements. The field is returned with the result on `esize_o`.
- R5: A word matches when `(instr_i & 32'hFF3FE000) == 32'h04192000`. `illegal_o` is high exactly when `in_valid_i` is high and the word does not match. An accepted non-matching word produces no result.
- R6: `src_idx_o = instr_i[9:5]` and `pred_idx_o = instr_i[12:10]` are combinational. `dst_idx_o` carries `instr_i[4:0]` of the accepted word along with its result.
- R7: Result bits at and above the element width are zero.
- R8: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o`, `result_o`, `dst_idx_o` and `esize_o` hold their values.
- R9: `in_ready_o = !out_valid_o || out_ready_i`. An input accepted in the same cycle that the held result is consumed becomes the next result without a bubble.
- R10: After reset, `out_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Input operands and word present |
| in_ready_o | output | 1 | Input accepted this cycle when valid |
| instr_i | input | 32 | Instruction word |
| vec_i | input | VLEN | Source vector |
| pred_i | input | VLEN/8 | Byte-granular predicate |
| illegal_o | output | 1 | Presented word fails opcode match |
| src_idx_o | output | 5 | Source vector register index |
| pred_idx_o | output | 3 | Predicate register index |
| out_valid_o | output | 1 | Result register full |
| out_ready_i | input | 1 | Consumer takes result |
| result_o | output | 64 | Zero-extended reduction result |
| dst_idx_o | output | 5 | Destination register index |
| esize_o | output | 2 | Element size code of the result |

## Verification
Two events can fall in the same cycle: the consumer draining a held result, and the acceptance of a new word. The new word may be either matching or illegal. The bench provokes this by keeping `in_valid_i` high while randomly dropping and raising `out_ready_i`, and by mixing corrupted opcode bits into the stream. A behavioural model tracks the register occupancy from the handshake rules. On every clock the model is compared against the result and its metadata, and against whether a matching word refills the register or an illegal one leaves it empty.

// File: rtl/xorv_pkg.sv
package xorv_pkg;
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned RES_W     = 64;
  localparam int unsigned INSTR_W   = 32;
  localparam logic [31:0] OPC_MASK  = 32'hFF3F_E000;
  localparam logic [31:0] OPC_BITS  = 32'h0419_2000;
endpackage

// File: rtl/xorv_decode.sv
module xorv_decode
  import xorv_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               match_o,
  output esz_e               esz_o,
  output logic [4:0]         dst_idx_o,
  output logic [4:0]         src_idx_o,
  output logic [2:0]         pred_idx_o
);
  assign match_o    = (instr_i & OPC_MASK) == OPC_BITS;
  assign esz_o      = esz_e'(instr_i[23:22]);
  assign pred_idx_o = instr_i[12:10];
  assign src_idx_o  = instr_i[9:5];
  assign dst_idx_o  = instr_i[4:0];
endmodule

// File: rtl/xorv_fold.sv
// Balanced XOR tree over NE lanes of EW bits; lanes gated by act_i.
module xorv_fold #(
  parameter int unsigned EW = 8,
  parameter int unsigned NE = 32
) (
  input  logic [NE*EW-1:0] vec_i,
  input  logic [NE-1:0]    act_i,
  output logic [EW-1:0]    res_o
);
  localparam int unsigned NODES = 2 * NE - 1;

  // heap order: node k (1-based) at bits [(k-1)*EW +: EW]
  logic [NODES*EW-1:0] heap;

  for (genvar e = 0; e < NE; e++) begin : g_leaf
    assign heap[(NE + e - 1)*EW +: EW] = vec_i[e*EW +: EW] & {EW{act_i[e]}};
  end

  for (genvar k = 1; k < NE; k++) begin : g_node
    assign heap[(k-1)*EW +: EW] = heap[(2*k-1)*EW +: EW] ^ heap[(2*k)*EW +: EW];
  end

  assign res_o = heap[0 +: EW];
endmodule

// File: rtl/xorv_unit.sv
module xorv_unit
  import xorv_pkg::*;
#(
  parameter int unsigned VLEN = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       instr_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [VLEN/8-1:0] pred_i,
  output logic              illegal_o,
  output logic [4:0]        src_idx_o,
  output logic [2:0]        pred_idx_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [63:0]       result_o,
  output logic [4:0]        dst_idx_o,
  output logic [1:0]        esize_o
);
  localparam int unsigned PW = VLEN / 8;

  logic       match;
  esz_e       esz;
  logic [4:0] dst_idx;
  logic       accept;

  logic [NUM_SIZES-1:0][RES_W-1:0] red_ext;
  logic [RES_W-1:0]                red_sel;

  xorv_decode u_decode (
    .instr_i    (instr_i),
    .match_o    (match),
    .esz_o      (esz),
    .dst_idx_o  (dst_idx),
    .src_idx_o  (src_idx_o),
    .pred_idx_o (pred_idx_o)
  );

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
    localparam int unsigned EW = 8 << s;
    localparam int unsigned NE = VLEN / EW;
    localparam int unsigned BPE = EW / 8;

    logic [NE-1:0] act;
    logic [EW-1:0] red;

    // lane active on its lowest byte's predicate bit
    for (genvar e = 0; e < NE; e++) begin : g_act
      assign act[e] = pred_i[e*BPE];
    end

    xorv_fold #(.EW(EW), .NE(NE)) u_fold (
      .vec_i (vec_i),
      .act_i (act),
      .res_o (red)
    );

    always_comb begin
      red_ext[s]       = '0;
      red_ext[s][EW-1:0] = red;
    end
  end

  assign red_sel    = red_ext[esz];
  assign illegal_o  = in_valid_i && !match;
  assign in_ready_o = !out_valid_o || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      dst_idx_o   <= '0;
      esize_o     <= '0;
    end else if (accept) begin
      out_valid_o <= match;
      if (match) begin
        result_o  <= red_sel;
        dst_idx_o <= dst_idx;
        esize_o   <= esz;
      end
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o)
      && $stable(dst_idx_o) && $stable(esize_o));

  p_illegal_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && illegal_o |=> !out_valid_o);

  p_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !illegal_o |=> out_valid_o);

  p_empty_pred_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !illegal_o && (pred_i == '0) |=> result_o == '0);

  p_zero_ext_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (esize_o != 2'd3) |-> (result_o >> (8 << esize_o)) == '0);

  p_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  initial begin
    assert (VLEN >= 128 && VLEN <= 2048 && (VLEN & (VLEN - 1)) == 0)
      else $error("VLEN must be a power of two in 128..2048");
    assert (PW * 8 == VLEN) else $error("predicate width mismatch");
  end
endmodule

// File: tb/xorv_unit_tb.sv
`timescale 1ns/1ps
module xorv_unit_tb;
  localparam int unsigned VLEN = 256;
  localparam int unsigned PW   = VLEN / 8;
  localparam logic [31:0] MASK = 32'hFF3F_E000;
  localparam logic [31:0] BITS = 32'h0419_2000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [31:0]     instr = '0;
  logic [VLEN-1:0] vec = '0;
  logic [PW-1:0]   pred = '0;
  logic            illegal;
  logic [4:0]      src_idx;
  logic [2:0]      pred_idx;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [63:0]     result;
  logic [4:0]      dst_idx;
  logic [1:0]      esize;

  always #10 clk = ~clk;

  xorv_unit #(.VLEN(VLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .instr_i(instr), .vec_i(vec), .pred_i(pred), .illegal_o(illegal),
    .src_idx_o(src_idx), .pred_idx_o(pred_idx), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .result_o(result), .dst_idx_o(dst_idx), .esize_o(esize)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_tag = "R1";

  bit          m_valid = 0;
  logic [63:0] m_res = '0;
  logic [4:0]  m_dst = '0;
  logic [1:0]  m_esz = '0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] ref_red(logic [VLEN-1:0] v, logic [PW-1:0] p, logic [1:0] sz);
    int w = 8 << sz;
    int n = VLEN / w;
    logic [63:0] acc = '0;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    for (int e = 0; e < n; e++)
      if (p[e*w/8]) acc ^= 64'(v >> (e*w)) & m;
    return acc;
  endfunction

  task automatic rand_vec();
    for (int k = 0; k < VLEN/32; k++) vec[k*32 +: 32] = $urandom;
    for (int k = 0; k < PW/32; k++) pred[k*32 +: 32] = $urandom;
  endtask

  function automatic logic [31:0] legal_word(logic [1:0] sz);
    return BITS | (32'(sz) << 22) | ($urandom & 32'h1FFF);
  endfunction

  function automatic logic [31:0] bad_word(logic [1:0] sz);
    int p;
    logic [31:0] w = legal_word(sz);
    p = $urandom_range(31, 0);
    while (!MASK[p]) p = $urandom_range(31, 0);
    return w ^ (32'd1 << p);
  endfunction

  // inputs already driven at negedge; one clock of compare + model update
  task automatic cycle();
    bit legal, rdy;
    #1;
    legal = (instr & MASK) == BITS;
    rdy   = !m_valid || out_ready;
    check("R9", 64'(in_ready), 64'(rdy));
    check("R5", 64'(illegal), 64'(in_valid && !legal));
    check("R6", 64'(src_idx), 64'(instr[9:5]));
    check("R6", 64'(pred_idx), 64'(instr[12:10]));
    @(posedge clk);
    if (in_valid && rdy) begin
      m_valid = legal;
      if (legal) begin
        m_res = ref_red(vec, pred, instr[23:22]);
        m_dst = instr[4:0];
        m_esz = instr[23:22];
      end
    end else if (out_ready) begin
      m_valid = 0;
    end
    @(negedge clk);
    check("R8", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      check(cur_tag, result, m_res);
      check("R6", 64'(dst_idx), 64'(m_dst));
      check("R4", 64'(esize), 64'(m_esz));
      if (m_esz != 2'd3) check("R7", result >> (8 << m_esz), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", 64'(out_valid), 64'd0);
    rst_ni = 1'b1;

    // R1 / R4: every size, full-rate, random predicates
    cur_tag = "R1";
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 20; i++) begin
        rand_vec(); in_valid = 1; out_ready = 1; instr = legal_word(2'(s));
        cycle();
      end

    // R2: nothing active
    cur_tag = "R2";
    for (int s = 0; s < 4; s++) begin
      rand_vec(); pred = '0; instr = legal_word(2'(s));
      cycle();
      check("R2", result, 64'd0);
    end

    // R3: only non-lowest predicate bits set -> zero; lowest only -> full XOR
    cur_tag = "R3";
    for (int s = 1; s < 4; s++) begin
      int bpe = 1 << s;
      rand_vec(); pred = '1;
      for (int b = 0; b < PW; b += bpe) pred[b] = 1'b0;
      instr = legal_word(2'(s));
      cycle();
      check("R3", result, 64'd0);
      pred = '0;
      for (int b = 0; b < PW; b += bpe) pred[b] = 1'b1;
      cycle();
    end

    // R5: corrupted opcode bits
    cur_tag = "R5";
    for (int i = 0; i < 30; i++) begin
      rand_vec(); instr = (i % 2 == 0) ? bad_word(2'($urandom)) : legal_word(2'($urandom));
      cycle();
    end

    // R8 / R9: back-pressure mixed with illegal words and idle cycles
    cur_tag = "R9";
    for (int i = 0; i < 600; i++) begin
      rand_vec();
      in_valid  = ($urandom_range(3, 0) != 0);
      out_ready = ($urandom_range(2, 0) != 0);
      instr = ($urandom_range(4, 0) == 0) ? bad_word(2'($urandom)) : legal_word(2'($urandom));
      cycle();
    end

    in_valid = 0; out_ready = 1;
    cycle();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule